// File: doc/BRIEF.md
# Input change-of-state detector

This block watches a small group of general-purpose input pins, four by default, and records each time one of them settles at a new level. The pins arrive without any timing relation to the system clock. They first pass through a synchroniser. A level is then accepted only after it has been seen on consecutive ticks of a sample-enable strobe, which removes short glitches. Each accepted change sets a sticky per-pin flag in an 8-bit port-change word. The same word also carries the current filtered level of every pin.

An accepted change also sets a shared input-change interrupt status bit, but only for pins whose enable bit is on. That status bit drives the active-low interrupt output only while the mask input is set. A one-cycle read strobe returns the port-change word in that same cycle. At the end of that cycle the strobe clears all change flags and the status bit.

Top module: `cos_detect`

## Requirements
- R1: After reset, all change flags, all filtered levels and the status bit are 0, and irq_no is 1.
- R2: A pin's filtered level takes a new value only after the synchronised pin has shown that value on STABLE_TICKS (default 2) consecutive sample ticks. At that point the level bit i (bit i of chg_reg_o) updates and change flag i (bit 4+i of chg_reg_o) sets.
- R3: A pin pulse that is seen on fewer than STABLE_TICKS consecutive sample ticks is ignored: no flag is set and the level is unchanged.
- R4: While sample_en_i is low, no level changes and no flag sets, however long a pin has been at a new level.
- R5: An accepted change on a pin whose chg_en_i bit is 1 sets isr_chg_o.
- R6: An accepted change on a pin whose chg_en_i bit is 0 sets its flag but leaves isr_chg_o unchanged.
- R7: irq_no is 0 exactly when isr_chg_o and irq_mask_i are both 1.
- R8: During a cycle with rd_i high, chg_reg_o shows the word as it was before the read. At the clock edge that ends the cycle, all flags and isr_chg_o clear. Level bits are not affected.
- R9: If a change is accepted in the same cycle as a read, the new flag (and isr_chg_o, if that pin is enabled) is set after the edge. Every other flag is cleared.
- R10: Flags are sticky: a flag stays set across further changes on any pin until a read.
- R11: Turning on an enable bit after that pin's flag has already been set does not set isr_chg_o.
- R12: Falling changes are detected in the same way as rising ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Monitored pins, asynchronous to clk_i |
| sample_en_i | input | 1 | One-cycle sample tick for the glitch filter |
| chg_en_i | input | NUM_PINS | Per-pin enable toward the status bit |
| irq_mask_i | input | 1 | Mask for the interrupt output |
| rd_i | input | 1 | Read strobe for the port-change word |
| chg_reg_o | output | 2*NUM_PINS | Change flags (upper half) and filtered levels (lower half) |
| isr_chg_o | output | 1 | Shared input-change status bit |
| irq_no | output | 1 | Active-low interrupt |

## Verification
A read-clear and a newly accepted change can land on the same clock edge, and that collision is the case that matters most here. The bench provokes it directly because it owns the sample tick. It gives the second qualifying tick in exactly the cycle in which rd_i is high, while another pin's flag is already set. It then checks three things. First, the word read in that cycle still shows the old flags. Second, after the edge the new flag and the status bit have survived. Third, the older flag is gone.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int unsigned COS_PINS         = 4;
  localparam int unsigned COS_SYNC_STAGES  = 2;
  localparam int unsigned COS_STABLE_TICKS = 2;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cos_filter.sv
module cos_filter #(
  parameter int unsigned STABLE_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  input  logic tick_i,
  output logic level_o,
  output logic chg_o
);
  localparam int unsigned CW = $clog2(STABLE_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          level_q;
  logic          differ, last;

  assign differ  = in_i != level_q;
  assign last    = cnt_q == CW'(STABLE_TICKS - 1);
  assign chg_o   = tick_i & differ & last;
  assign level_o = level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (tick_i) begin
      if (!differ) begin
        cnt_q <= '0;
      end else if (last) begin
        cnt_q   <= '0;
        level_q <= in_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R4
  level_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_q) |-> $past(tick_i));

  // R2
  accept_moves_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |=> !$stable(level_q));
endmodule

// File: rtl/cos_flags.sv
module cos_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] chg_i,
  input  logic [N-1:0] en_i,
  input  logic         rd_i,
  output logic [N-1:0] flags_o,
  output logic         isr_o
);
  logic [N-1:0] flags_q;
  logic         isr_q;

  // set wins over read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      isr_q   <= 1'b0;
    end else begin
      flags_q <= (rd_i ? '0 : flags_q) | chg_i;
      isr_q   <= (rd_i ? 1'b0 : isr_q) | (|(chg_i & en_i));
    end
  end

  assign flags_o = flags_q;
  assign isr_o   = isr_q;

  // R5, R6, R11
  isr_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(isr_q) |-> $past(|(chg_i & en_i)));

  // R8
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !(|chg_i)) |=> (flags_q == '0 && !isr_q));

  for (genvar i = 0; i < N; i++) begin : g_bit
    // R2
    flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flags_q[i]) |-> $past(chg_i[i]));
    // R10
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_q[i] && !rd_i) |=> flags_q[i]);
  end
endmodule

// File: rtl/cos_detect.sv
module cos_detect
  import cos_pkg::*;
#(
  parameter int unsigned NUM_PINS     = COS_PINS,
  parameter int unsigned SYNC_STAGES  = COS_SYNC_STAGES,
  parameter int unsigned STABLE_TICKS = COS_STABLE_TICKS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PINS-1:0]   pins_i,
  input  logic                  sample_en_i,
  input  logic [NUM_PINS-1:0]   chg_en_i,
  input  logic                  irq_mask_i,
  input  logic                  rd_i,
  output logic [2*NUM_PINS-1:0] chg_reg_o,
  output logic                  isr_chg_o,
  output logic                  irq_no
);
  logic [NUM_PINS-1:0] pins_s, level, chg, flags;
  logic                isr;

  cos_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (pins_s)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    cos_filter #(.STABLE_TICKS(STABLE_TICKS)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_i   (pins_s[i]),
      .tick_i (sample_en_i),
      .level_o(level[i]),
      .chg_o  (chg[i])
    );
  end

  cos_flags #(.N(NUM_PINS)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .chg_i  (chg),
    .en_i   (chg_en_i),
    .rd_i   (rd_i),
    .flags_o(flags),
    .isr_o  (isr)
  );

  assign chg_reg_o = {flags, level};
  assign isr_chg_o = isr;
  assign irq_no    = ~(isr & irq_mask_i);

  // R1
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !isr_chg_o |-> irq_no);
endmodule

// File: tb/cos_detect_tb_top.sv
`timescale 1ns/1ps
module cos_detect_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] pins_i = '0;
  logic       sample_en_i = 1'b0;
  logic [3:0] chg_en_i = '0;
  logic       irq_mask_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] chg_reg_o;
  logic       isr_chg_o, irq_no;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk_i = ~clk_i;

  cos_detect dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pins_i(pins_i), .sample_en_i(sample_en_i),
    .chg_en_i(chg_en_i), .irq_mask_i(irq_mask_i), .rd_i(rd_i),
    .chg_reg_o(chg_reg_o), .isr_chg_o(isr_chg_o), .irq_no(irq_no)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive new pin levels and give exactly two qualifying ticks
  task automatic accept(logic [3:0] v);
    @(negedge clk_i); pins_i = v; sample_en_i = 1'b0; rd_i = 1'b0;
    repeat (2) @(negedge clk_i);
    sample_en_i = 1'b1;
    repeat (2) @(negedge clk_i);
    sample_en_i = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] d);
    @(negedge clk_i);
    d = chg_reg_o;
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reg", chg_reg_o, 8'h00);
    chk("R1 isr", isr_chg_o, 1'b0);
    chk("R1 irq", irq_no, 1'b1);
  endtask

  task automatic t_rise_enabled();
    logic [7:0] d;
    chg_en_i = 4'b0001; irq_mask_i = 1'b1;
    accept(4'b0001);
    chk("R2 reg", chg_reg_o, 8'h11);
    chk("R5 isr", isr_chg_o, 1'b1);
    chk("R7 irq low", irq_no, 1'b0);
    do_read(d);
    chk("R8 read data", d, 8'h11);
    chk("R8 cleared", chg_reg_o, 8'h01);
    chk("R8 isr cleared", isr_chg_o, 1'b0);
    chk("R7 irq high", irq_no, 1'b1);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    chg_en_i = 4'b0010; irq_mask_i = 1'b0;
    accept(4'b0011);
    chk("R2 reg", chg_reg_o, 8'h23);
    chk("R5 isr", isr_chg_o, 1'b1);
    chk("R7 masked", irq_no, 1'b1);
    irq_mask_i = 1'b1;
    #1;
    chk("R7 unmasked", irq_no, 1'b0);
    do_read(d);
    chk("R8 read data", d, 8'h23);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    chg_en_i = 4'b0000;
    accept(4'b0111);
    chk("R6 flag", chg_reg_o, 8'h47);
    chk("R6 isr", isr_chg_o, 1'b0);
    chk("R6 irq", irq_no, 1'b1);
    chg_en_i = 4'b0100;
    repeat (5) @(negedge clk_i);
    chk("R11 isr", isr_chg_o, 1'b0);
    chk("R11 irq", irq_no, 1'b1);
    do_read(d);
    chk("R8 read data", d, 8'h47);
  endtask

  task automatic t_fall_sticky();
    logic [7:0] d;
    chg_en_i = 4'b1111;
    accept(4'b0110);
    chk("R12 fall", chg_reg_o, 8'h16);
    chk("R12 isr", isr_chg_o, 1'b1);
    accept(4'b0100);
    chk("R10 sticky", chg_reg_o, 8'h34);
    do_read(d);
    chk("R10 read data", d, 8'h34);
    chk("R8 levels kept", chg_reg_o, 8'h04);
  endtask

  task automatic t_glitch();
    @(negedge clk_i); pins_i = 4'b1100; sample_en_i = 1'b1;
    @(negedge clk_i); pins_i = 4'b0100;
    repeat (8) @(negedge clk_i);
    sample_en_i = 1'b0;
    chk("R3 glitch", chg_reg_o, 8'h04);
  endtask

  task automatic t_no_tick();
    logic [7:0] d;
    @(negedge clk_i); pins_i = 4'b1100; sample_en_i = 1'b0;
    repeat (10) @(negedge clk_i);
    chk("R4 no tick", chg_reg_o, 8'h04);
    sample_en_i = 1'b1;
    @(negedge clk_i);
    chk("R2 one tick", chg_reg_o, 8'h04);
    @(negedge clk_i);
    sample_en_i = 1'b0;
    chk("R2 two ticks", chg_reg_o, 8'h8C);
    do_read(d);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    chg_en_i = 4'b0001; irq_mask_i = 1'b1;
    accept(4'b1110);
    chk("R9 setup", chg_reg_o, 8'h2E);
    @(negedge clk_i); pins_i = 4'b1111; sample_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    sample_en_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b1;
    d = chg_reg_o;
    chk("R9 read data", d, 8'h2E);
    @(negedge clk_i);
    rd_i = 1'b0; sample_en_i = 1'b0;
    chk("R9 set wins", chg_reg_o, 8'h1F);
    chk("R9 isr", isr_chg_o, 1'b1);
    chk("R9 irq", irq_no, 1'b0);
    do_read(d);
    chk("R8 after", chg_reg_o, 8'h0F);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_rise_enabled();
    t_mask();
    t_disabled();
    t_fall_sticky();
    t_glitch();
    t_no_tick();
    t_collision();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule